// File: doc/BRIEF.md
# Dual-Clock Serial Field Memory Controller

This block stores one field of samples that is written and read strictly in address order. The writer and the reader each run on their own clock and each keeps its own address pointer. The only thing the two sides share is the storage array. A pointer-reset strobe starts a new pass on either side. On each side, an advance enable decides whether the pointer moves. A second, separate enable decides whether a sample moves. This lets a pass skip over stored locations without disturbing them, or repeat a location without moving on.

Write samples are first gathered in a small block register. They are committed to the array a whole block at a time, once the block is full. A partially filled block waits in the register until the next write pointer reset, which then commits it with a per-lane mask. Write controls are taken through one extra register stage, so the write side acts one clock later than the read side. A static start-timing input chooses whether the reset cycle itself already stores a sample. Each pass must contain a minimum number of active cycles. A pass that is too short is reported by a one-cycle flag on the reset that ends it.

The data interface is a plain stream with no back-pressure. On the write side, the input enable marks a sample as valid, and the block always accepts it. On the read side, the output-valid flag stands in for a driven bus, and a low flag means the output is in high impedance. The downstream side cannot stall the reader; it simply samples whenever the output-valid flag is high.

Top module: `fmem_ctrl`

## Requirements
- R1: A write cycle with advance enable and input enable both high stores the sample at the write pointer, and the pointer moves on by one.
- R2: A write cycle with advance enable high and input enable low moves the write pointer on, but the location it passes keeps its earlier contents.
- R3: With write advance enable low, the write pointer holds and no sample is stored, whatever the input enable level.
- R4: A read cycle with both read enables high presents the word at the read pointer with output-valid high, and the pointer moves on by one.
- R5: Read advance high with output enable low moves the pointer on with output-valid low. Read advance low with output enable high holds the pointer and presents the word at the pointer with output-valid high. Both enables low hold the pointer with output-valid low.
- R6: Written samples reach the array only when their block of BLK locations fills, or on the next write pointer reset. Until then a read returns the earlier contents. The partial-block commit changes only the lanes that were written.
- R7: After the block reset, all write activity is ignored until the first write pointer reset.
- R8: With start_late low, a reset cycle that has advance enable high uses location 0, storing the sample if input enable is high, and the pass continues at location 1. With start_late high, the reset cycle stores nothing and the first sample of the pass goes to location 0.
- R9: Both pointers wrap from DEPTH-1 to 0. A pointer reset returns its pointer to 0, and the read reset cycle itself presents nothing.
- R10: A pointer reset raises that side's short-run flag for one cycle when the pass it ends had fewer than MIN_RUN active cycles. An active cycle is one with both enables high. The first reset after the block reset never raises the flag.
- R11: Write controls act one write clock later than read controls. The write short-run flag appears two write edges after the reset is sampled, while the read flag appears one read edge after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low block reset for both sides |
| start_late | input | 1 | Static start timing: 0 uses the reset cycle, 1 starts one cycle after it |
| w_rst | input | 1 | Write pointer reset strobe |
| w_we | input | 1 | Write advance enable |
| w_ie | input | 1 | Write input enable (sample valid) |
| w_din | input | DW | Write sample |
| r_rst | input | 1 | Read pointer reset strobe |
| r_re | input | 1 | Read advance enable |
| r_oe | input | 1 | Read output enable |
| r_dout | output | DW | Read sample |
| r_valid | output | 1 | Output driven; low stands for high impedance |
| w_short | output | 1 | One-cycle flag: the write pass just ended was too short |
| r_short | output | 1 | One-cycle flag: the read pass just ended was too short |

## Verification
Several pointer rules are checked on every clock of their own domain: the read pointer stepping, holding and clearing, the output-valid level that follows the output enable, the write pointer holding after the delayed stage, the write pointer restarting after a reset, and each short-run flag being caused by a reset. The bench's scenarios alone can show what ends up in storage. That covers skipped locations keeping old data, block contents staying invisible until they are committed, the two start timings, and writes being ignored before initialisation. The bench shows these by writing whole passes, reading them back across the wrap, and comparing against an arithmetic model of the array.

// File: rtl/fmem_pkg.sv
`timescale 1ns/1ps
package fmem_pkg;

  // Read-side operation, encoded as {advance, output}.
  typedef enum logic [1:0] {
    OP_HOLD_HIZ  = 2'b00,
    OP_HOLD_SHOW = 2'b01,
    OP_STEP_HIZ  = 2'b10,
    OP_STEP_SHOW = 2'b11
  } rd_op_e;

  // Next pointer value with wrap at the array depth.
  function automatic logic [31:0] ptr_next(input logic [31:0] p, input int unsigned depth);
    return (p == 32'(depth - 1)) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/fmem_runchk.sv
`timescale 1ns/1ps
// Counts active cycles of a pass and flags a pass that ends too early.
module fmem_runchk #(
  parameter int MIN_RUN = 140
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic restart_hit,
  input  logic hit,
  output logic short_o
);
  localparam int CW = $clog2(MIN_RUN + 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      short_o <= 1'b0;
    end else if (restart) begin
      short_o <= armed && (cnt < CW'(MIN_RUN));
      armed   <= 1'b1;
      cnt     <= restart_hit ? CW'(1) : '0;
    end else begin
      short_o <= 1'b0;
      if (hit && (cnt < CW'(MIN_RUN))) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fmem_wr_port.sv
`timescale 1ns/1ps
// Write side: delayed control stage, pointer, block gather register, commit.
module fmem_wr_port
  import fmem_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int BLK     = 4,
  parameter int MIN_RUN = 140,
  parameter int AW      = $clog2(DEPTH),
  parameter int SW      = $clog2(BLK)
) (
  input  logic                    wclk,
  input  logic                    rst_n,
  input  logic                    start_late,
  input  logic                    w_rst,
  input  logic                    w_we,
  input  logic                    w_ie,
  input  logic [DW-1:0]           w_din,
  output logic                    cm_v,
  output logic [AW-SW-1:0]        cm_blk,
  output logic [BLK-1:0][DW-1:0]  cm_data,
  output logic [BLK-1:0]          cm_mask,
  output logic [AW-1:0]           wptr,
  output logic                    w_short
);
  // one-clock lag stage on every write control
  logic          st_rst, st_we, st_ie;
  logic [DW-1:0] st_din;
  logic          init;

  logic [BLK-1:0][DW-1:0] bufq, buf_n;
  logic [BLK-1:0]         maskq, mask_n;

  logic [SW-1:0]    slot;
  logic [AW-SW-1:0] blk;
  logic             cap, put;

  assign slot = wptr[SW-1:0];
  assign blk  = wptr[AW-1:SW];
  assign cap  = st_we && (st_rst ? !start_late : init);
  assign put  = cap && st_ie;

  always_comb begin
    buf_n  = bufq;
    mask_n = maskq;
    if (put) begin
      buf_n[slot]  = st_din;
      mask_n[slot] = 1'b1;
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      st_rst  <= 1'b0;
      st_we   <= 1'b0;
      st_ie   <= 1'b0;
      st_din  <= '0;
      init    <= 1'b0;
      bufq    <= '0;
      maskq   <= '0;
      wptr    <= '0;
      cm_v    <= 1'b0;
      cm_blk  <= '0;
      cm_data <= '0;
      cm_mask <= '0;
    end else begin
      st_rst <= w_rst;
      st_we  <= w_we;
      st_ie  <= w_ie;
      st_din <= w_din;
      cm_v   <= 1'b0;
      if (st_rst) begin
        init    <= 1'b1;
        cm_v    <= init && (|maskq);
        cm_blk  <= blk;
        cm_data <= bufq;
        cm_mask <= maskq;
        maskq   <= '0;
        if (put) begin
          maskq[0] <= 1'b1;
          bufq[0]  <= st_din;
        end
        wptr <= cap ? AW'(1) : '0;
      end else if (cap) begin
        bufq <= buf_n;
        wptr <= AW'(ptr_next(32'(wptr), DEPTH));
        if (slot == SW'(BLK - 1)) begin
          cm_v    <= |mask_n;
          cm_blk  <= blk;
          cm_data <= buf_n;
          cm_mask <= mask_n;
          maskq   <= '0;
        end else begin
          maskq <= mask_n;
        end
      end
    end
  end

  fmem_runchk #(.MIN_RUN(MIN_RUN)) u_run (
    .clk        (wclk),
    .rst_n      (rst_n),
    .restart    (st_rst),
    .restart_hit(put),
    .hit        (put),
    .short_o    (w_short)
  );
endmodule

// File: rtl/fmem_store.sv
`timescale 1ns/1ps
// Storage array organised as BLK lanes, each lane with its own write mask bit.
module fmem_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int BLK   = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int SW    = $clog2(BLK)
) (
  input  logic                   wclk,
  input  logic                   cm_v,
  input  logic [AW-SW-1:0]       cm_blk,
  input  logic [BLK-1:0][DW-1:0] cm_data,
  input  logic [BLK-1:0]         cm_mask,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_word
);
  localparam int ROWS = DEPTH / BLK;

  logic [BLK-1:0][DW-1:0] lane_out;

  for (genvar j = 0; j < BLK; j++) begin : g_lane
    logic [DW-1:0] cells [ROWS];
    always_ff @(posedge wclk) begin
      if (cm_v && cm_mask[j]) cells[cm_blk] <= cm_data[j];
    end
    assign lane_out[j] = cells[rd_addr[AW-1:SW]];
  end

  assign rd_word = lane_out[rd_addr[SW-1:0]];
endmodule

// File: rtl/fmem_rd_port.sv
`timescale 1ns/1ps
// Read side: pointer, output register and output-valid (high impedance when low).
module fmem_rd_port
  import fmem_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int MIN_RUN = 140,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          r_rst,
  input  logic          r_re,
  input  logic          r_oe,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rptr,
  output logic [DW-1:0] r_dout,
  output logic          r_valid,
  output logic          r_short
);
  rd_op_e op;
  assign op = rd_op_e'({r_re, r_oe});

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr    <= '0;
      r_dout  <= '0;
      r_valid <= 1'b0;
    end else if (r_rst) begin
      rptr    <= '0;
      r_valid <= 1'b0;
    end else begin
      unique case (op)
        OP_STEP_SHOW: begin
          r_dout  <= rd_word;
          r_valid <= 1'b1;
          rptr    <= AW'(ptr_next(32'(rptr), DEPTH));
        end
        OP_STEP_HIZ: begin
          r_valid <= 1'b0;
          rptr    <= AW'(ptr_next(32'(rptr), DEPTH));
        end
        OP_HOLD_SHOW: begin
          r_dout  <= rd_word;
          r_valid <= 1'b1;
        end
        default: r_valid <= 1'b0;
      endcase
    end
  end

  fmem_runchk #(.MIN_RUN(MIN_RUN)) u_run (
    .clk        (rclk),
    .rst_n      (rst_n),
    .restart    (r_rst),
    .restart_hit(1'b0),
    .hit        ((op == OP_STEP_SHOW) && !r_rst),
    .short_o    (r_short)
  );
endmodule

// File: rtl/fmem_ctrl.sv
`timescale 1ns/1ps
module fmem_ctrl #(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int BLK     = 4,
  parameter int MIN_RUN = 140
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          start_late,
  input  logic          w_rst,
  input  logic          w_we,
  input  logic          w_ie,
  input  logic [DW-1:0] w_din,
  input  logic          r_rst,
  input  logic          r_re,
  input  logic          r_oe,
  output logic [DW-1:0] r_dout,
  output logic          r_valid,
  output logic          w_short,
  output logic          r_short
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(BLK);

  logic                   cm_v;
  logic [AW-SW-1:0]       cm_blk;
  logic [BLK-1:0][DW-1:0] cm_data;
  logic [BLK-1:0]         cm_mask;
  logic [AW-1:0]          wr_ptr, rd_ptr;
  logic [DW-1:0]          rd_word;

  fmem_wr_port #(
    .DW(DW), .DEPTH(DEPTH), .BLK(BLK), .MIN_RUN(MIN_RUN), .AW(AW), .SW(SW)
  ) u_wr (
    .wclk      (wclk),
    .rst_n     (rst_n),
    .start_late(start_late),
    .w_rst     (w_rst),
    .w_we      (w_we),
    .w_ie      (w_ie),
    .w_din     (w_din),
    .cm_v      (cm_v),
    .cm_blk    (cm_blk),
    .cm_data   (cm_data),
    .cm_mask   (cm_mask),
    .wptr      (wr_ptr),
    .w_short   (w_short)
  );

  fmem_store #(
    .DW(DW), .DEPTH(DEPTH), .BLK(BLK), .AW(AW), .SW(SW)
  ) u_store (
    .wclk   (wclk),
    .cm_v   (cm_v),
    .cm_blk (cm_blk),
    .cm_data(cm_data),
    .cm_mask(cm_mask),
    .rd_addr(rd_ptr),
    .rd_word(rd_word)
  );

  fmem_rd_port #(
    .DW(DW), .DEPTH(DEPTH), .MIN_RUN(MIN_RUN), .AW(AW)
  ) u_rd (
    .rclk   (rclk),
    .rst_n  (rst_n),
    .r_rst  (r_rst),
    .r_re   (r_re),
    .r_oe   (r_oe),
    .rd_word(rd_word),
    .rptr   (rd_ptr),
    .r_dout (r_dout),
    .r_valid(r_valid),
    .r_short(r_short)
  );
endmodule

// File: rtl/fmem_chk.sv
`timescale 1ns/1ps
module fmem_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          w_rst,
  input logic          w_we,
  input logic          w_short,
  input logic          r_rst,
  input logic          r_re,
  input logic          r_oe,
  input logic          r_valid,
  input logic          r_short,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr
);
  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  AST_RD_STEP: assert property (@(posedge rclk) disable iff (!rst_n)
    (r_re && !r_rst) |=> (rd_ptr == nxt($past(rd_ptr)))); // R4
  AST_RD_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
    (!r_re && !r_rst) |=> $stable(rd_ptr)); // R5
  AST_RD_ZERO: assert property (@(posedge rclk) disable iff (!rst_n)
    r_rst |=> (rd_ptr == '0)); // R9
  AST_RD_SHOW: assert property (@(posedge rclk) disable iff (!rst_n)
    (r_oe && !r_rst) |=> r_valid); // R4
  AST_RD_HIZ: assert property (@(posedge rclk) disable iff (!rst_n)
    (!r_oe || r_rst) |=> !r_valid); // R5
  AST_WR_HOLD: assert property (@(posedge wclk) disable iff (!rst_n)
    (!w_we && !w_rst) |=> ##1 $stable(wr_ptr)); // R3
  AST_WR_RESTART: assert property (@(posedge wclk) disable iff (!rst_n)
    w_rst |=> ##1 (wr_ptr <= AW'(1))); // R9
  AST_WSHORT_CAUSE: assert property (@(posedge wclk) disable iff (!rst_n)
    w_short |-> $past(w_rst, 2)); // R11
  AST_RSHORT_CAUSE: assert property (@(posedge rclk) disable iff (!rst_n)
    r_short |-> $past(r_rst)); // R10
endmodule

bind fmem_ctrl fmem_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .wclk   (wclk),
  .rclk   (rclk),
  .rst_n  (rst_n),
  .w_rst  (w_rst),
  .w_we   (w_we),
  .w_short(w_short),
  .r_rst  (r_rst),
  .r_re   (r_re),
  .r_oe   (r_oe),
  .r_valid(r_valid),
  .r_short(r_short),
  .wr_ptr (wr_ptr),
  .rd_ptr (rd_ptr)
);

// File: tb/tb_fmem_ctrl.sv
`timescale 1ns/1ps
module tb_fmem_ctrl;
  localparam int DW = 8, D = 16, BLK = 4, MINR = 20;
  localparam int WP = 10;   // write clock period
  localparam int RP = 14;   // read clock period

  logic wclk = 0, rclk = 0, rst_n = 0, start_late = 0;
  logic w_rst = 0, w_we = 0, w_ie = 0;
  logic [DW-1:0] w_din = '0;
  logic r_rst = 0, r_re = 0, r_oe = 0;
  logic [DW-1:0] r_dout;
  logic r_valid, w_short, r_short;

  fmem_ctrl #(.DW(DW), .DEPTH(D), .BLK(BLK), .MIN_RUN(MINR)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .start_late(start_late),
    .w_rst(w_rst), .w_we(w_we), .w_ie(w_ie), .w_din(w_din),
    .r_rst(r_rst), .r_re(r_re), .r_oe(r_oe), .r_dout(r_dout),
    .r_valid(r_valid), .w_short(w_short), .r_short(r_short));

  initial forever #(WP/2) wclk = ~wclk;
  initial forever #(RP/2) rclk = ~rclk;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  // model: committed array, pending gather contents
  logic [DW-1:0] mem_m [D];
  logic [DW-1:0] pend_m [D];
  bit pv [D];
  int wptr_m = 0, wcnt = 0, rptr_m = 0, rcnt = 0;
  bit winit = 0, warmed = 0, ws_pipe = 0, rarmed = 0;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] f(input int i, input int s);
    return DW'(i * 37 + s * 11 + 5);
  endfunction

  task automatic commit_blk(input int b);
    for (int j = 0; j < BLK; j++) begin
      if (pv[b*BLK+j]) begin
        mem_m[b*BLK+j] = pend_m[b*BLK+j];
        pv[b*BLK+j] = 0;
      end
    end
  endtask

  task automatic wcycle(input bit rst, input bit we, input bit ie, input logic [DW-1:0] d);
    bit exp_now, cap, put;
    @(negedge wclk);
    w_rst = rst; w_we = we; w_ie = ie; w_din = d;
    exp_now = ws_pipe;
    if (rst) begin
      cap = we && !start_late;
      put = cap && ie;
      ws_pipe = warmed && (wcnt < MINR);
      if (winit) commit_blk(wptr_m / BLK);
      winit = 1; warmed = 1;
      wcnt = put ? 1 : 0;
      wptr_m = 0;
      if (put) begin pend_m[0] = d; pv[0] = 1; end
      if (cap) wptr_m = 1;
    end else begin
      ws_pipe = 0;
      cap = we && winit;
      put = cap && ie;
      if (put) begin
        pend_m[wptr_m] = d; pv[wptr_m] = 1;
        if (wcnt < MINR) wcnt++;
      end
      if (cap) begin
        if (wptr_m % BLK == BLK - 1) commit_blk(wptr_m / BLK);
        wptr_m = (wptr_m + 1) % D;
      end
    end
    @(posedge wclk); #1;
    chk(w_short === exp_now, "R10 write short flag", int'(w_short), int'(exp_now));
  endtask

  task automatic widle(input int n);
    for (int i = 0; i < n; i++) wcycle(0, 0, 0, '0);
  endtask

  task automatic rcycle(input bit rst, input bit re, input bit oe, input string tag);
    bit ev, es;
    logic [DW-1:0] ed;
    ed = '0;
    @(negedge rclk);
    r_rst = rst; r_re = re; r_oe = oe;
    if (rst) begin
      es = rarmed && (rcnt < MINR);
      rarmed = 1; rcnt = 0; rptr_m = 0; ev = 0;
    end else begin
      es = 0; ev = oe;
      if (oe) ed = mem_m[rptr_m];
      if (re && oe && rcnt < MINR) rcnt++;
      if (re) rptr_m = (rptr_m + 1) % D;
    end
    @(posedge rclk); #1;
    chk(r_valid === ev, tag, int'(r_valid), int'(ev));
    if (ev) chk(r_dout === ed, tag, int'(r_dout), int'(ed));
    chk(r_short === es, "R10 read short flag", int'(r_short), int'(es));
  endtask

  task automatic read_all(input string tag);
    rcycle(1, 0, 0, "R9 read reset");
    for (int i = 0; i < MINR; i++) rcycle(0, 1, 1, tag);
    @(negedge rclk); r_rst = 0; r_re = 0; r_oe = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(WP * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
  end

  initial begin
    for (int a = 0; a < D; a++) begin mem_m[a] = '0; pend_m[a] = '0; pv[a] = 0; end
    repeat (3) @(negedge wclk);
    rst_n = 1;
    #1;
    chk(r_valid === 1'b0, "R4 reset valid", int'(r_valid), 0);
    chk(w_short === 1'b0, "R10 reset write flag", int'(w_short), 0);
    chk(r_short === 1'b0, "R10 reset read flag", int'(r_short), 0);

    // R1 / R8 / R9: start in reset cycle, wrap the array
    start_late = 0;
    wcycle(1, 1, 1, f(0, 1));
    for (int i = 1; i < 22; i++) wcycle(0, 1, 1, f(i, 1));
    wcycle(1, 0, 0, '0);
    widle(4);
    read_all("R1 full pass with wrap");

    // R2 / R3 / R6: skipped locations, halted pointer, pending block unseen
    wcycle(1, 1, 1, f(0, 2));
    for (int i = 1; i < 30; i++) begin
      if (i % 7 == 3)      wcycle(0, 0, i[0], f(i, 2));
      else if (i % 5 == 2) wcycle(0, 1, 0, f(i, 2));
      else                 wcycle(0, 1, 1, f(i, 2));
    end
    widle(4);
    read_all("R6 pending block not visible");
    wcycle(1, 0, 0, '0);
    widle(4);
    read_all("R2 R3 skip and halt");

    // R8: late start ignores reset-cycle sample
    start_late = 1;
    wcycle(1, 1, 1, 8'hA5);
    for (int i = 1; i < 25; i++) wcycle(0, 1, 1, f(i, 3));
    wcycle(1, 0, 0, '0);
    widle(4);
    read_all("R8 late start");

    // R10 / R11: short passes, lag of write flag
    start_late = 0;
    wcycle(1, 1, 1, f(0, 4));
    for (int i = 1; i < 5; i++) wcycle(0, 1, 1, f(i, 4));
    wcycle(1, 0, 0, '0);
    chk(w_short === 1'b0, "R11 write flag not yet", int'(w_short), 0);
    wcycle(0, 0, 0, '0);
    chk(w_short === 1'b1, "R11 write flag after lag", int'(w_short), 1);
    widle(4);
    rcycle(1, 0, 0, "R9 read reset");
    for (int i = 0; i < 3; i++) rcycle(0, 1, 1, "R4 short read");
    rcycle(1, 0, 0, "R9 read reset");
    chk(r_short === 1'b1, "R11 read flag no lag", int'(r_short), 1);

    // R5: read enable combinations
    rcycle(1, 0, 0, "R5 reset");
    rcycle(0, 1, 1, "R4 step show");
    rcycle(0, 0, 1, "R5 hold show");
    rcycle(0, 0, 1, "R5 hold show again");
    rcycle(0, 1, 0, "R5 step hiz");
    rcycle(0, 0, 0, "R5 hold hiz");
    rcycle(0, 1, 1, "R5 step show after skip");

    // R7: writes before the first write reset are ignored
    @(negedge wclk);
    rst_n = 0;
    winit = 0; warmed = 0; wcnt = 0; wptr_m = 0; ws_pipe = 0;
    rarmed = 0; rcnt = 0; rptr_m = 0;
    for (int a = 0; a < D; a++) pv[a] = 0;
    repeat (2) @(negedge wclk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) wcycle(0, 1, 1, 8'h3C);
    start_late = 1;
    wcycle(1, 0, 0, '0);
    widle(4);
    read_all("R7 ignored before init");

    summary();
  end
endmodule